// File: doc/BRIEF.md
# Timer and Monitor Interrupt Entry

This block decides, cycle by cycle, whether a pending user-decrementer exception or a pending performance-monitor exception is taken as an interrupt. When one is taken, it produces everything the core needs to enter the handler in that cycle:

- the redirected fetch address;
- the values to load into the two save/restore registers;
- the new machine-state word.

The decision is combinational from the current machine-state word, the per-source enables, a blocking input from higher-priority logic and the pending status. It is signalled by a one-cycle take strobe for each source.

The user-decrementer status bit lives inside the block. A one-cycle event from the decrementer sets it. A write-one-to-clear software write clears it. Taking the interrupt leaves the bit as it is, so software must clear it before it restores the enable, or the interrupt is taken again. The performance-monitor exception is an external level that the block only reads.

The machine-state word is 32 bits wide, and its bit positions are parameters. With the default values:

| Bit | Role |
|-----|------|
| 31 | computation mode |
| 28 | guest state |
| 17 | critical enable |
| 15 | external enable |
| 12 | machine-check enable |
| 9 | debug enable |

The fetch address is the 20-bit vector prefix concatenated with a 12-bit offset.

Top module: `tmr_irq_entry`

## Requirements
- R1: `ud_take_o` is 1 exactly when `hi_pri_i` is 0, `udis_o` is 1, `ud_en_i` is 1, and machine-state bit 15 or bit 28 is 1.
- R2: `pm_take_o` is 1 exactly when `hi_pri_i` is 0, `pm_exc_i` is 1, machine-state bit 15 or bit 28 is 1, and `ud_take_o` is 0. `ud_en_i` has no effect on it.
- R3: When both sources qualify in the same cycle, only `ud_take_o` is 1. At most one take strobe is high in any cycle.
- R4: On a user-decrementer take, `fetch_addr_o` is {`ivp_i`, 12'h800}. On a performance-monitor take, it is {`ivp_i`, 12'h820}.
- R5: On either take, `srr0_o` equals `nia_i` and `srr1_o` equals `msr_i`.
- R6: On either take, `msr_o` copies bits 17, 12 and 9 from `msr_i` and sets bit 31 to `icm_i`. Every other bit is 0. This word, fed back as `msr_i`, allows no further take.
- R7: With no take, `msr_o` equals `msr_i`, and `srr0_o`, `srr1_o` and `fetch_addr_o` are 0.
- R8: `udis_o` is set one cycle after `dec_evt_i`. It stays set through taken interrupts and through writes with `clr_bit_i` 0. It clears one cycle after `clr_we_i` with `clr_bit_i` 1.
- R9: A decrementer event in the same cycle as a clearing write leaves `udis_o` at 1.
- R10: After reset `udis_o` is 0, and no take occurs until a new event arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_evt_i | input | 1 | Decrementer exception event, one cycle |
| clr_we_i | input | 1 | Software write strobe to the status bit |
| clr_bit_i | input | 1 | Write data; 1 clears the status bit |
| ud_en_i | input | 1 | User-decrementer interrupt enable |
| pm_exc_i | input | 1 | Performance-monitor exception pending |
| hi_pri_i | input | 1 | A higher-priority exception is pending |
| msr_i | input | 32 | Current machine-state word |
| icm_i | input | 1 | Computation mode to enter handlers in |
| ivp_i | input | 20 | Vector prefix |
| nia_i | input | 32 | Address of the next instruction |
| ud_take_o | output | 1 | User-decrementer interrupt taken this cycle |
| pm_take_o | output | 1 | Performance-monitor interrupt taken this cycle |
| fetch_addr_o | output | 32 | Handler fetch address |
| srr0_o | output | 32 | New save/restore register 0 value |
| srr1_o | output | 32 | New save/restore register 1 value |
| msr_o | output | 32 | New machine-state word |
| udis_o | output | 1 | User-decrementer status bit |

## Verification
The hardest situation to reach from the ports is a decrementer event colliding with a clearing write in the same cycle. The bench reaches it by holding both strobes for one clock and then reading `udis_o`.

A second case needs care: the status bit must survive a cycle in which the interrupt is actually taken. The bench reaches it by leaving the enable on across a clock edge with the take strobe high.

A table of twelve enable, pending and blocking combinations covers the qualification and priority rules. Before each entry, the bench sets or clears the status bit through the event and clear ports.

// File: rtl/tmr_irq_entry.sv
module tmr_irq_entry #(
  parameter int AW    = 32,
  parameter int MW    = 32,
  parameter int OFS_W = 12,
  parameter int CM_B  = 31,
  parameter int GS_B  = 28,
  parameter int CE_B  = 17,
  parameter int EE_B  = 15,
  parameter int ME_B  = 12,
  parameter int DE_B  = 9,
  parameter logic [OFS_W-1:0] UD_OFS = 12'h800,
  parameter logic [OFS_W-1:0] PM_OFS = 12'h820
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_evt_i,
  input  logic          clr_we_i,
  input  logic          clr_bit_i,
  input  logic          ud_en_i,
  input  logic          pm_exc_i,
  input  logic          hi_pri_i,
  input  logic [MW-1:0] msr_i,
  input  logic          icm_i,
  input  logic [AW-OFS_W-1:0] ivp_i,
  input  logic [AW-1:0] nia_i,
  output logic          ud_take_o,
  output logic          pm_take_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic [AW-1:0] srr0_o,
  output logic [MW-1:0] srr1_o,
  output logic [MW-1:0] msr_o,
  output logic          udis_o
);
  localparam logic [MW-1:0] KEEP = (MW'(1) << CE_B) | (MW'(1) << ME_B) | (MW'(1) << DE_B);

  logic udis_q;
  logic ext_en;
  logic take;
  logic [MW-1:0] entry_msr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      udis_q <= 1'b0;
    else if (dec_evt_i)
      udis_q <= 1'b1;
    else if (clr_we_i && clr_bit_i)
      udis_q <= 1'b0;
  end

  assign ext_en    = msr_i[EE_B] | msr_i[GS_B];
  assign ud_take_o = ~hi_pri_i & ext_en & udis_q & ud_en_i;
  assign pm_take_o = ~hi_pri_i & ext_en & pm_exc_i & ~ud_take_o;
  assign take      = ud_take_o | pm_take_o;

  assign entry_msr = (msr_i & KEEP) | (MW'(icm_i) << CM_B);

  assign fetch_addr_o = ud_take_o ? {ivp_i, UD_OFS} :
                        pm_take_o ? {ivp_i, PM_OFS} : '0;
  assign srr0_o = take ? nia_i : '0;
  assign srr1_o = take ? msr_i : '0;
  assign msr_o  = take ? entry_msr : msr_i;
  assign udis_o = udis_q;
endmodule

// File: rtl/tmr_irq_entry_chk.sv
module tmr_irq_entry_chk #(
  parameter int MW   = 32,
  parameter int CM_B = 31,
  parameter int GS_B = 28,
  parameter int CE_B = 17,
  parameter int EE_B = 15,
  parameter int ME_B = 12,
  parameter int DE_B = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_evt_i,
  input logic          clr_we_i,
  input logic          clr_bit_i,
  input logic          ud_en_i,
  input logic          pm_exc_i,
  input logic          hi_pri_i,
  input logic [MW-1:0] msr_i,
  input logic          icm_i,
  input logic          ud_take_o,
  input logic          pm_take_o,
  input logic [MW-1:0] msr_o,
  input logic          udis_o
);
  a_r1_ud_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    ud_take_o |-> (udis_o && ud_en_i && !hi_pri_i && (msr_i[EE_B] || msr_i[GS_B])));

  a_r2_pm_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    pm_take_o |-> (pm_exc_i && !hi_pri_i && (msr_i[EE_B] || msr_i[GS_B])));

  a_r3_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ud_take_o, pm_take_o}));

  a_r6_entry_msr: assert property (@(posedge clk) disable iff (!rst_n)
    (ud_take_o || pm_take_o) |-> (!msr_o[EE_B] && !msr_o[GS_B] && msr_o[CM_B] == icm_i &&
      msr_o[CE_B] == msr_i[CE_B] && msr_o[ME_B] == msr_i[ME_B] && msr_o[DE_B] == msr_i[DE_B]));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (udis_o && !(clr_we_i && clr_bit_i)) |=> udis_o);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt_i |=> udis_o);
endmodule

bind tmr_irq_entry tmr_irq_entry_chk #(
  .MW(MW), .CM_B(CM_B), .GS_B(GS_B), .CE_B(CE_B), .EE_B(EE_B), .ME_B(ME_B), .DE_B(DE_B)
) u_chk (.*);

// File: tb/sim_tmr_irq_entry.sv
module sim_tmr_irq_entry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_evt_i = 1'b0, clr_we_i = 1'b0, clr_bit_i = 1'b0;
  logic        ud_en_i = 1'b0, pm_exc_i = 1'b0, hi_pri_i = 1'b0, icm_i = 1'b0;
  logic [31:0] msr_i = '0, nia_i = '0;
  logic [19:0] ivp_i = '0;
  logic        ud_take_o, pm_take_o, udis_o;
  logic [31:0] fetch_addr_o, srr0_o, srr1_o, msr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_irq_entry u0 (.*);

  // {set_udis, ud_en, pm, hi, ee, gs, exp_ud, exp_pm}
  localparam logic [7:0] VEC [12] = '{
    8'b1_1_0_0_1_0_1_0, 8'b1_1_0_0_0_1_1_0, 8'b1_1_0_0_0_0_0_0, 8'b1_0_0_0_1_0_0_0,
    8'b1_1_0_1_1_1_0_0, 8'b0_1_0_0_1_1_0_0, 8'b0_0_1_0_1_0_0_1, 8'b0_1_1_0_0_1_0_1,
    8'b1_1_1_0_1_0_1_0, 8'b1_0_1_0_1_0_0_1, 8'b0_0_1_1_1_1_0_0, 8'b0_0_1_0_0_0_0_0
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] entry_msr(input logic [31:0] m, input logic icm);
    logic [31:0] r = '0;
    r[17] = m[17]; r[12] = m[12]; r[9] = m[9]; r[31] = icm;
    return r;
  endfunction

  task automatic pulse_evt();
    @(negedge clk); dec_evt_i = 1'b1;
    @(negedge clk); dec_evt_i = 1'b0;
  endtask

  task automatic pulse_clr(input logic b);
    @(negedge clk); clr_we_i = 1'b1; clr_bit_i = b;
    @(negedge clk); clr_we_i = 1'b0; clr_bit_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    ud_en_i = 1'b1; msr_i = 32'h0000_8000;
    #1;
    chk(udis_o == 1'b0, "R10 status in reset", {31'b0, udis_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(udis_o == 1'b0 && !ud_take_o, "R10 no take after reset", {30'b0, udis_o, ud_take_o}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      logic [31:0] m;
      v = VEC[i];
      ud_en_i = 1'b0; pm_exc_i = 1'b0;
      if (v[7]) pulse_evt(); else pulse_clr(1'b1);
      m = 32'h5A5A_3C3C & ~32'h1000_8000;
      m[15] = v[3]; m[28] = v[2];
      ud_en_i = v[6]; pm_exc_i = v[5]; hi_pri_i = v[4]; msr_i = m;
      icm_i = i[0]; ivp_i = 20'h1_0000 + 20'(i); nia_i = 32'h1000_0000 + 32'(i * 4);
      #1;
      chk(ud_take_o == v[1], "R1 ud take", {31'b0, ud_take_o}, {31'b0, v[1]});
      chk(pm_take_o == v[0], "R2 R3 pm take", {31'b0, pm_take_o}, {31'b0, v[0]});
      if (v[1]) chk(fetch_addr_o == {ivp_i, 12'h800}, "R4 ud vector", fetch_addr_o, {ivp_i, 12'h800});
      if (v[0]) chk(fetch_addr_o == {ivp_i, 12'h820}, "R4 pm vector", fetch_addr_o, {ivp_i, 12'h820});
      if (v[1] || v[0]) begin
        chk(srr0_o == nia_i, "R5 srr0", srr0_o, nia_i);
        chk(srr1_o == m, "R5 srr1", srr1_o, m);
        chk(msr_o == entry_msr(m, icm_i), "R6 entry msr", msr_o, entry_msr(m, icm_i));
      end else begin
        chk(msr_o == m && srr0_o == 0 && srr1_o == 0 && fetch_addr_o == 0, "R7 idle outputs", msr_o, m);
      end
      hi_pri_i = 1'b0;
    end

    // R8: status survives a taken interrupt and a zero write
    ud_en_i = 1'b1; pm_exc_i = 1'b0; msr_i = 32'h0000_8000;
    pulse_evt();
    chk(ud_take_o == 1'b1, "R8 take before edge", {31'b0, ud_take_o}, 32'h1);
    @(negedge clk);
    chk(udis_o == 1'b1 && ud_take_o, "R8 sticky through take", {31'b0, udis_o}, 32'h1);
    pulse_clr(1'b0);
    chk(udis_o == 1'b1, "R8 zero write ignored", {31'b0, udis_o}, 32'h1);

    // R9: set beats clear
    @(negedge clk); dec_evt_i = 1'b1; clr_we_i = 1'b1; clr_bit_i = 1'b1;
    @(negedge clk); dec_evt_i = 1'b0; clr_we_i = 1'b0; clr_bit_i = 1'b0;
    chk(udis_o == 1'b1, "R9 event beats clear", {31'b0, udis_o}, 32'h1);
    pulse_clr(1'b1);
    chk(udis_o == 1'b0 && !ud_take_o, "R8 w1c clears", {31'b0, udis_o}, 32'h0);

    // R6 field boundaries and feedback
    ud_en_i = 1'b0; pm_exc_i = 1'b1; msr_i = 32'hFFFF_FFFF; icm_i = 1'b0;
    #1;
    chk(msr_o == 32'h0002_1200, "R6 all ones kept fields", msr_o, 32'h0002_1200);
    msr_i = 32'h1000_0000; icm_i = 1'b1;
    #1;
    chk(msr_o == 32'h8000_0000, "R6 cm from mode", msr_o, 32'h8000_0000);
    msr_i = 32'hFFFF_FFFF; icm_i = 1'b1;
    #1;
    msr_i = msr_o;
    #1;
    chk(!pm_take_o && !ud_take_o, "R6 fed back blocks take", {30'b0, ud_take_o, pm_take_o}, 32'h0);
    chk(msr_o == msr_i, "R7 unchanged when idle", msr_o, msr_i);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule